// File: doc/BRIEF.md
# Fetch-and-Add Combining Switch

This is one node of a combining tree that sits between two upstream requesters and one path toward memory. Each upstream port delivers fetch-and-add requests, each an address, an increment and a small requester id. When both ports offer a request for the same address in the same cycle and a wait-buffer slot is free, the node sends one request downstream whose increment is the sum of the two. The slot remembers how to split the answer. All other requests go downstream one at a time, unchanged.

Memory answers each downstream request with the value the variable held before the add, and applies the add itself. Every reply carries the tag of its request. A reply for a single request goes back to its own port. A reply for a merged pair is split in two: port 0 receives the returned value and port 1 receives the returned value plus port 0's increment. Every requester therefore sees a distinct result, as if the adds had happened one after another. Replies may come back in any order.

Every data path is valid/ready. A transfer happens on a rising edge where both valid and ready are high. A source that raises valid holds it, with its payload unchanged, until the transfer. The node's downstream request and its two reply outputs are registers that follow this rule. An upstream ready may depend on the valids and addresses offered in the same cycle. The downstream reply ready depends on the tag that is offered.

Top module: `fa_comb_switch`

## Requirements
- R1: When both upstream ports are valid with equal addresses and a wait-buffer slot is free, both are accepted in the same cycle. The next downstream request carries that address and the sum of the increments, modulo 2^DATA_W. Its tag has the top bit set to 1 and the slot index in its low bits.
- R2: Any other request is forwarded with its address and increment unchanged. Its tag has the top bit 0, bit ID_W holding the source port, and bits ID_W-1:0 holding the requester id. When both ports are valid but cannot be merged, grants alternate between the ports, and port 0 goes first after reset.
- R3: When every wait-buffer slot is busy, same-address requests are forwarded uncombined, one per cycle, following R2.
- R4: A merge takes the lowest-numbered free slot. The slot becomes free again in the cycle its reply is accepted.
- R5: A reply whose tag top bit is 1 is presented on both reply outputs in the next cycle. Port 0 gets the returned value with its own id. Port 1 gets the returned value plus port 0's increment, with its own id.
- R6: A reply whose tag top bit is 0 is presented, in the next cycle, on the port named by bit ID_W, with the returned value unchanged and the id from bits ID_W-1:0.
- R7: While a downstream request or a reply output is valid and not ready, it stays valid and its payload stays unchanged.
- R8: A merged reply is accepted only when both reply outputs are empty or draining in that cycle. A single reply is accepted only when its own output is empty or draining.
- R9: After reset, no output is valid, the wait buffer is empty and the next grant goes to port 0.
- R10: Starting from 5, increments 1 and 1 merged, followed by a lone 2, return the values 5, 6 and 7 and leave 9 in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| up0_valid | input | 1 | Port 0 request valid |
| up0_ready | output | 1 | Port 0 request accepted |
| up0_addr | input | ADDR_W | Port 0 variable address |
| up0_inc | input | DATA_W | Port 0 increment |
| up0_id | input | ID_W | Port 0 requester id |
| up1_valid | input | 1 | Port 1 request valid |
| up1_ready | output | 1 | Port 1 request accepted |
| up1_addr | input | ADDR_W | Port 1 variable address |
| up1_inc | input | DATA_W | Port 1 increment |
| up1_id | input | ID_W | Port 1 requester id |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_addr | output | ADDR_W | Downstream address |
| dn_req_inc | output | DATA_W | Downstream increment (summed when merged) |
| dn_req_tag | output | TAG_W | Routing tag, layout in R1 and R2 |
| dn_rep_valid | input | 1 | Reply from memory valid |
| dn_rep_ready | output | 1 | Reply accepted |
| dn_rep_tag | input | TAG_W | Tag of the answered request |
| dn_rep_value | input | DATA_W | Value before the add |
| up0_rsp_valid | output | 1 | Port 0 result valid |
| up0_rsp_ready | input | 1 | Port 0 result accepted |
| up0_rsp_value | output | DATA_W | Port 0 result value |
| up0_rsp_id | output | ID_W | Port 0 result requester id |
| up1_rsp_valid | output | 1 | Port 1 result valid |
| up1_rsp_ready | input | 1 | Port 1 result accepted |
| up1_rsp_value | output | DATA_W | Port 1 result value |
| up1_rsp_id | output | ID_W | Port 1 result requester id |

## Verification
The assertions check several properties on every cycle. Payloads hold under back-pressure. A double handshake produces a merged request with the summed increment, and a lone handshake produces an unchanged one. A single reply lands on its named port. A merged reply fills both outputs with the returned value on port 0. The buffer never allocates when full and never frees an idle slot. The bench's scenarios show the rest: lowest-slot choice and reuse, fall-back to uncombined forwarding when the buffer is full, port alternation, the plus-increment value on port 1 under out-of-order replies, and the serialized results of the 5, 1, 1, 2 case.

// File: rtl/fa_comb_pkg.sv
package fa_comb_pkg;

  typedef enum logic {
    KIND_SINGLE = 1'b0,
    KIND_PAIR   = 1'b1
  } tag_kind_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fa_free_finder.sv
module fa_free_finder #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2
) (
  input  logic [DEPTH-1:0] busy,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // scan downward so the lowest free slot wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/fa_wait_buf.sv
module fa_wait_buf #(
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [DATA_W-1:0] alloc_inc,
  input  logic [ID_W-1:0]   alloc_id0,
  input  logic [ID_W-1:0]   alloc_id1,
  output logic [IDX_W-1:0]  alloc_idx,
  output logic              full,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_inc,
  output logic [ID_W-1:0]   rd_id0,
  output logic [ID_W-1:0]   rd_id1,
  input  logic              free_en,
  input  logic [IDX_W-1:0]  free_idx
);

  logic [DEPTH-1:0]  busy_q;
  logic [DEPTH-1:0]  set_hit;
  logic [DEPTH-1:0]  clr_hit;
  logic [DATA_W-1:0] inc_q [DEPTH];
  logic [ID_W-1:0]   id0_q [DEPTH];
  logic [ID_W-1:0]   id1_q [DEPTH];
  logic              any_free;

  fa_free_finder #(.DEPTH(DEPTH), .IDX_W(IDX_W)) finder_i (
    .busy  (busy_q),
    .found (any_free),
    .idx   (alloc_idx)
  );

  assign full = !any_free;

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot_dec
    assign set_hit[e] = alloc_en && (alloc_idx == IDX_W'(e));
    assign clr_hit[e] = free_en  && (free_idx  == IDX_W'(e));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
    end else begin
      busy_q <= (busy_q & ~clr_hit) | set_hit;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (set_hit[e]) begin
        inc_q[e] <= alloc_inc;
        id0_q[e] <= alloc_id0;
        id1_q[e] <= alloc_id1;
      end
    end
  end

  assign rd_inc = inc_q[rd_idx];
  assign rd_id0 = id0_q[rd_idx];
  assign rd_id1 = id1_q[rd_idx];

  // R3
  no_alloc_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full);

  // R4
  free_busy_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |-> busy_q[free_idx]);

  // R4
  alloc_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> busy_q[$past(alloc_idx)]);

endmodule

// File: rtl/fa_req_merge.sv
module fa_req_merge
  import fa_comb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int ID_W   = 4,
  parameter int IDX_W  = 2,
  parameter int PAY_W  = 5,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up0_valid,
  output logic              up0_ready,
  input  logic [ADDR_W-1:0] up0_addr,
  input  logic [DATA_W-1:0] up0_inc,
  input  logic [ID_W-1:0]   up0_id,
  input  logic              up1_valid,
  output logic              up1_ready,
  input  logic [ADDR_W-1:0] up1_addr,
  input  logic [DATA_W-1:0] up1_inc,
  input  logic [ID_W-1:0]   up1_id,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic [ADDR_W-1:0] dn_req_addr,
  output logic [DATA_W-1:0] dn_req_inc,
  output logic [TAG_W-1:0]  dn_req_tag,
  input  logic              buf_full,
  input  logic [IDX_W-1:0]  alloc_idx,
  output logic              alloc_en,
  output logic [DATA_W-1:0] alloc_inc,
  output logic [ID_W-1:0]   alloc_id0,
  output logic [ID_W-1:0]   alloc_id1
);

  logic              out_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] inc_q;
  logic [TAG_W-1:0]  tag_q;
  logic              turn1_q;

  logic              slot_open;
  logic              merge;
  logic              pick0;
  logic              pick1;
  logic              both_up;
  logic [PAY_W-1:0]  pay_pair;
  logic [PAY_W-1:0]  pay_single;

  assign slot_open = !out_q || dn_req_ready;
  assign both_up   = up0_valid && up1_valid;
  assign merge     = both_up && (up0_addr == up1_addr) && !buf_full;
  assign pick1     = !merge && up1_valid && (!up0_valid || turn1_q);
  assign pick0     = !merge && up0_valid && !pick1;

  assign up0_ready = slot_open && (merge || pick0);
  assign up1_ready = slot_open && (merge || pick1);

  assign alloc_en  = slot_open && merge;
  assign alloc_inc = up0_inc;
  assign alloc_id0 = up0_id;
  assign alloc_id1 = up1_id;

  always_comb begin
    pay_pair              = '0;
    pay_pair[IDX_W-1:0]   = alloc_idx;
    pay_single            = '0;
    pay_single[ID_W]      = pick1;
    pay_single[ID_W-1:0]  = pick1 ? up1_id : up0_id;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q   <= 1'b0;
      addr_q  <= '0;
      inc_q   <= '0;
      tag_q   <= '0;
      turn1_q <= 1'b0;
    end else if (slot_open) begin
      if (merge) begin
        out_q  <= 1'b1;
        addr_q <= up0_addr;
        inc_q  <= up0_inc + up1_inc;
        tag_q  <= {KIND_PAIR, pay_pair};
      end else if (pick0 || pick1) begin
        out_q  <= 1'b1;
        addr_q <= pick1 ? up1_addr : up0_addr;
        inc_q  <= pick1 ? up1_inc : up0_inc;
        tag_q  <= {KIND_SINGLE, pay_single};
        if (both_up) turn1_q <= pick0;
      end else begin
        out_q <= 1'b0;
      end
    end
  end

  assign dn_req_valid = out_q;
  assign dn_req_addr  = addr_q;
  assign dn_req_inc   = inc_q;
  assign dn_req_tag   = tag_q;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_addr)
      && $stable(dn_req_inc) && $stable(dn_req_tag));

  // R1
  pair_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up0_valid && up0_ready && up1_valid && up1_ready |=> dn_req_valid
      && dn_req_tag[TAG_W-1] && dn_req_inc == DATA_W'($past(up0_inc) + $past(up1_inc)));

  // R2
  lone0_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up0_valid && up0_ready && !(up1_valid && up1_ready) |=> dn_req_valid
      && !dn_req_tag[TAG_W-1] && dn_req_inc == $past(up0_inc)
      && dn_req_addr == $past(up0_addr));

endmodule

// File: rtl/fa_rsp_split.sv
module fa_rsp_split #(
  parameter int DATA_W = 16,
  parameter int ID_W   = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dn_rep_valid,
  output logic              dn_rep_ready,
  input  logic [TAG_W-1:0]  dn_rep_tag,
  input  logic [DATA_W-1:0] dn_rep_value,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_inc,
  input  logic [ID_W-1:0]   rd_id0,
  input  logic [ID_W-1:0]   rd_id1,
  output logic              free_en,
  output logic [IDX_W-1:0]  free_idx,
  output logic              up0_rsp_valid,
  input  logic              up0_rsp_ready,
  output logic [DATA_W-1:0] up0_rsp_value,
  output logic [ID_W-1:0]   up0_rsp_id,
  output logic              up1_rsp_valid,
  input  logic              up1_rsp_ready,
  output logic [DATA_W-1:0] up1_rsp_value,
  output logic [ID_W-1:0]   up1_rsp_id
);

  logic [1:0]        vld_q;
  logic [DATA_W-1:0] val_q [2];
  logic [ID_W-1:0]   id_q  [2];
  logic [1:0]        drain;
  logic [1:0]        room;
  logic [1:0]        load;
  logic              is_pair;
  logic              dest;
  logic              take;
  logic [DATA_W-1:0] nval [2];
  logic [ID_W-1:0]   nid  [2];

  assign drain   = {up1_rsp_ready, up0_rsp_ready};
  assign room    = ~vld_q | drain;
  assign is_pair = dn_rep_tag[TAG_W-1];
  assign dest    = dn_rep_tag[ID_W];
  assign rd_idx  = dn_rep_tag[IDX_W-1:0];

  assign dn_rep_ready = is_pair ? (room[0] && room[1]) : room[dest];
  assign take         = dn_rep_valid && dn_rep_ready;
  assign load[0]      = take && (is_pair || !dest);
  assign load[1]      = take && (is_pair || dest);
  assign free_en      = take && is_pair;
  assign free_idx     = rd_idx;

  always_comb begin
    nval[0] = dn_rep_value;
    nid[0]  = is_pair ? rd_id0 : dn_rep_tag[ID_W-1:0];
    nval[1] = is_pair ? dn_rep_value + rd_inc : dn_rep_value;
    nid[1]  = is_pair ? rd_id1 : dn_rep_tag[ID_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int p = 0; p < 2; p++) begin
        val_q[p] <= '0;
        id_q[p]  <= '0;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (load[p]) begin
          vld_q[p] <= 1'b1;
          val_q[p] <= nval[p];
          id_q[p]  <= nid[p];
        end else if (drain[p]) begin
          vld_q[p] <= 1'b0;
        end
      end
    end
  end

  assign up0_rsp_valid = vld_q[0];
  assign up0_rsp_value = val_q[0];
  assign up0_rsp_id    = id_q[0];
  assign up1_rsp_valid = vld_q[1];
  assign up1_rsp_value = val_q[1];
  assign up1_rsp_id    = id_q[1];

  // R7
  rsp0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up0_rsp_valid && !up0_rsp_ready |=> up0_rsp_valid && $stable(up0_rsp_value)
      && $stable(up0_rsp_id));

  // R7
  rsp1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up1_rsp_valid && !up1_rsp_ready |=> up1_rsp_valid && $stable(up1_rsp_value)
      && $stable(up1_rsp_id));

  // R6
  single_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_rep_valid && dn_rep_ready && !dn_rep_tag[TAG_W-1] && dn_rep_tag[ID_W]
      |=> up1_rsp_valid && up1_rsp_value == $past(dn_rep_value)
      && up1_rsp_id == $past(dn_rep_tag[ID_W-1:0]));

  // R5
  pair_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_rep_valid && dn_rep_ready && dn_rep_tag[TAG_W-1]
      |=> up0_rsp_valid && up1_rsp_valid && up0_rsp_value == $past(dn_rep_value));

endmodule

// File: rtl/fa_comb_switch.sv
module fa_comb_switch
  import fa_comb_pkg::*;
#(
  parameter  int ADDR_W = 16,
  parameter  int DATA_W = 16,
  parameter  int ID_W   = 4,
  parameter  int DEPTH  = 4,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PAY_W  = int'(max2(ID_W + 1, IDX_W)),
  localparam int TAG_W  = PAY_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up0_valid,
  output logic              up0_ready,
  input  logic [ADDR_W-1:0] up0_addr,
  input  logic [DATA_W-1:0] up0_inc,
  input  logic [ID_W-1:0]   up0_id,
  input  logic              up1_valid,
  output logic              up1_ready,
  input  logic [ADDR_W-1:0] up1_addr,
  input  logic [DATA_W-1:0] up1_inc,
  input  logic [ID_W-1:0]   up1_id,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic [ADDR_W-1:0] dn_req_addr,
  output logic [DATA_W-1:0] dn_req_inc,
  output logic [TAG_W-1:0]  dn_req_tag,
  input  logic              dn_rep_valid,
  output logic              dn_rep_ready,
  input  logic [TAG_W-1:0]  dn_rep_tag,
  input  logic [DATA_W-1:0] dn_rep_value,
  output logic              up0_rsp_valid,
  input  logic              up0_rsp_ready,
  output logic [DATA_W-1:0] up0_rsp_value,
  output logic [ID_W-1:0]   up0_rsp_id,
  output logic              up1_rsp_valid,
  input  logic              up1_rsp_ready,
  output logic [DATA_W-1:0] up1_rsp_value,
  output logic [ID_W-1:0]   up1_rsp_id
);

  logic              alloc_en;
  logic [DATA_W-1:0] alloc_inc;
  logic [ID_W-1:0]   alloc_id0;
  logic [ID_W-1:0]   alloc_id1;
  logic [IDX_W-1:0]  alloc_idx;
  logic              buf_full;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rd_inc;
  logic [ID_W-1:0]   rd_id0;
  logic [ID_W-1:0]   rd_id1;
  logic              free_en;
  logic [IDX_W-1:0]  free_idx;

  fa_req_merge #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
    .IDX_W(IDX_W), .PAY_W(PAY_W), .TAG_W(TAG_W)
  ) merge_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .up0_valid    (up0_valid),
    .up0_ready    (up0_ready),
    .up0_addr     (up0_addr),
    .up0_inc      (up0_inc),
    .up0_id       (up0_id),
    .up1_valid    (up1_valid),
    .up1_ready    (up1_ready),
    .up1_addr     (up1_addr),
    .up1_inc      (up1_inc),
    .up1_id       (up1_id),
    .dn_req_valid (dn_req_valid),
    .dn_req_ready (dn_req_ready),
    .dn_req_addr  (dn_req_addr),
    .dn_req_inc   (dn_req_inc),
    .dn_req_tag   (dn_req_tag),
    .buf_full     (buf_full),
    .alloc_idx    (alloc_idx),
    .alloc_en     (alloc_en),
    .alloc_inc    (alloc_inc),
    .alloc_id0    (alloc_id0),
    .alloc_id1    (alloc_id1)
  );

  fa_wait_buf #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W), .ID_W(ID_W)
  ) wbuf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_en),
    .alloc_inc (alloc_inc),
    .alloc_id0 (alloc_id0),
    .alloc_id1 (alloc_id1),
    .alloc_idx (alloc_idx),
    .full      (buf_full),
    .rd_idx    (rd_idx),
    .rd_inc    (rd_inc),
    .rd_id0    (rd_id0),
    .rd_id1    (rd_id1),
    .free_en   (free_en),
    .free_idx  (free_idx)
  );

  fa_rsp_split #(
    .DATA_W(DATA_W), .ID_W(ID_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) split_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .dn_rep_valid  (dn_rep_valid),
    .dn_rep_ready  (dn_rep_ready),
    .dn_rep_tag    (dn_rep_tag),
    .dn_rep_value  (dn_rep_value),
    .rd_idx        (rd_idx),
    .rd_inc        (rd_inc),
    .rd_id0        (rd_id0),
    .rd_id1        (rd_id1),
    .free_en       (free_en),
    .free_idx      (free_idx),
    .up0_rsp_valid (up0_rsp_valid),
    .up0_rsp_ready (up0_rsp_ready),
    .up0_rsp_value (up0_rsp_value),
    .up0_rsp_id    (up0_rsp_id),
    .up1_rsp_valid (up1_rsp_valid),
    .up1_rsp_ready (up1_rsp_ready),
    .up1_rsp_value (up1_rsp_value),
    .up1_rsp_id    (up1_rsp_id)
  );

endmodule

// File: tb/fa_comb_switch_tb_top.sv
module fa_comb_switch_tb_top;
  import fa_comb_pkg::*;

  localparam int AW  = 16;
  localparam int DW  = 16;
  localparam int IW  = 4;
  localparam int DEP = 4;
  localparam int IXW = $clog2(DEP);
  localparam int PW  = int'(max2(IW + 1, IXW));
  localparam int TW  = PW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          up0_valid, up0_ready, up1_valid, up1_ready;
  logic [AW-1:0] up0_addr, up1_addr;
  logic [DW-1:0] up0_inc, up1_inc;
  logic [IW-1:0] up0_id, up1_id;
  logic          dn_req_valid, dn_req_ready;
  logic [AW-1:0] dn_req_addr;
  logic [DW-1:0] dn_req_inc;
  logic [TW-1:0] dn_req_tag;
  logic          dn_rep_valid, dn_rep_ready;
  logic [TW-1:0] dn_rep_tag;
  logic [DW-1:0] dn_rep_value;
  logic          up0_rsp_valid, up0_rsp_ready, up1_rsp_valid, up1_rsp_ready;
  logic [DW-1:0] up0_rsp_value, up1_rsp_value;
  logic [IW-1:0] up0_rsp_id, up1_rsp_id;

  fa_comb_switch #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .DEPTH(DEP)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .up0_valid(up0_valid), .up0_ready(up0_ready), .up0_addr(up0_addr),
    .up0_inc(up0_inc), .up0_id(up0_id),
    .up1_valid(up1_valid), .up1_ready(up1_ready), .up1_addr(up1_addr),
    .up1_inc(up1_inc), .up1_id(up1_id),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
    .dn_req_addr(dn_req_addr), .dn_req_inc(dn_req_inc), .dn_req_tag(dn_req_tag),
    .dn_rep_valid(dn_rep_valid), .dn_rep_ready(dn_rep_ready),
    .dn_rep_tag(dn_rep_tag), .dn_rep_value(dn_rep_value),
    .up0_rsp_valid(up0_rsp_valid), .up0_rsp_ready(up0_rsp_ready),
    .up0_rsp_value(up0_rsp_value), .up0_rsp_id(up0_rsp_id),
    .up1_rsp_valid(up1_rsp_valid), .up1_rsp_ready(up1_rsp_ready),
    .up1_rsp_value(up1_rsp_value), .up1_rsp_id(up1_rsp_id)
  );

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; logic [IW-1:0] id; } rq_t;
  typedef struct packed { logic [TW-1:0] t; logic [DW-1:0] v; } rp_t;

  rq_t q0[$];
  rq_t q1[$];
  rp_t pend[$];
  int  mem[int];
  int  got[$];
  int  pair_idx[$];

  // reference model state
  logic          m_rv;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_inc;
  logic [TW-1:0] m_tag;
  logic          m_rr;
  logic          m_hold;
  logic [DEP-1:0] m_busy;
  logic [DW-1:0] m_inc0 [DEP];
  logic [IW-1:0] m_id0  [DEP];
  logic [IW-1:0] m_id1  [DEP];
  logic          m_sv   [2];
  logic [DW-1:0] m_sval [2];
  logic [IW-1:0] m_sid  [2];
  string         m_slab [2];

  bit a0, a1, rtake;
  int p_in, p_rdy, p_rsp, p_rep;
  bit stall_mem, reorder;
  int n_chk = 0;
  int n_fail = 0;
  int cnt_pair, cnt_single;

  function automatic bit roll(int p);
    return $urandom_range(99) < p;
  endfunction

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic model_cycle();
    bit full, ofree, pair, g0, g1, e0r, e1r, err, ispair;
    logic [DEP-1:0] busy_pre;
    logic [1:0] rdy;
    int lo;
    string lab;
    full  = &m_busy;
    ofree = !m_rv || dn_req_ready;
    pair  = up0_valid && up1_valid && (up0_addr == up1_addr) && !full;
    g1    = !pair && up1_valid && (!up0_valid || m_rr);
    g0    = !pair && up0_valid && !g1;
    e0r   = ofree && (pair || g0);
    e1r   = ofree && (pair || g1);
    rdy   = {up1_rsp_ready, up0_rsp_ready};
    ispair = dn_rep_tag[TW-1];
    err   = ispair ? ((!m_sv[0] || rdy[0]) && (!m_sv[1] || rdy[1]))
                   : (!m_sv[dn_rep_tag[IW]] || rdy[dn_rep_tag[IW]]);
    // compare
    lab = pair ? "R1" : (full ? "R3" : "R2");
    chk(up0_ready == e0r, {lab, " up0_ready"}, 64'(up0_ready), 64'(e0r));
    chk(up1_ready == e1r, {lab, " up1_ready"}, 64'(up1_ready), 64'(e1r));
    lab = m_hold ? "R7" : (m_tag[TW-1] ? "R1/R4" : "R2");
    chk(dn_req_valid == m_rv, {lab, " dn_req_valid"}, 64'(dn_req_valid), 64'(m_rv));
    if (m_rv)
      chk({dn_req_addr, dn_req_inc, dn_req_tag} == {m_addr, m_inc, m_tag},
          {lab, " dn_req payload"}, 64'({dn_req_addr, dn_req_inc, dn_req_tag}),
          64'({m_addr, m_inc, m_tag}));
    chk(up0_rsp_valid == m_sv[0], "R8 up0_rsp_valid", 64'(up0_rsp_valid), 64'(m_sv[0]));
    chk(up1_rsp_valid == m_sv[1], "R8 up1_rsp_valid", 64'(up1_rsp_valid), 64'(m_sv[1]));
    if (m_sv[0])
      chk({up0_rsp_value, up0_rsp_id} == {m_sval[0], m_sid[0]}, {m_slab[0], " up0 result"},
          64'({up0_rsp_value, up0_rsp_id}), 64'({m_sval[0], m_sid[0]}));
    if (m_sv[1])
      chk({up1_rsp_value, up1_rsp_id} == {m_sval[1], m_sid[1]}, {m_slab[1], " up1 result"},
          64'({up1_rsp_value, up1_rsp_id}), 64'({m_sval[1], m_sid[1]}));
    if (dn_rep_valid)
      chk(dn_rep_ready == err, "R8 dn_rep_ready", 64'(dn_rep_ready), 64'(err));
    // advance
    a0 = up0_valid && e0r;
    a1 = up1_valid && e1r;
    rtake = dn_rep_valid && err;
    m_hold = m_rv && !dn_req_ready;
    if (m_rv && dn_req_ready) begin
      int old;
      old = mem.exists(int'(m_addr)) ? mem[int'(m_addr)] : 0;
      mem[int'(m_addr)] = (old + int'(m_inc)) & ((1 << DW) - 1);
      pend.push_back({m_tag, DW'(old)});
      if (m_tag[TW-1]) begin
        cnt_pair++;
        pair_idx.push_back(int'(m_tag[IXW-1:0]));
      end else cnt_single++;
    end
    for (int p = 0; p < 2; p++)
      if (m_sv[p] && rdy[p]) begin
        got.push_back(int'(m_sval[p]));
        m_sv[p] = 1'b0;
      end
    busy_pre = m_busy;
    if (ofree) begin
      if (pair) begin
        lo = -1;
        for (int i = DEP - 1; i >= 0; i--) if (!busy_pre[i]) lo = i;
        m_busy[lo] = 1'b1;
        m_inc0[lo] = up0_inc; m_id0[lo] = up0_id; m_id1[lo] = up1_id;
        m_rv = 1'b1; m_addr = up0_addr; m_inc = DW'(up0_inc + up1_inc);
        m_tag = '0; m_tag[TW-1] = 1'b1; m_tag[IXW-1:0] = IXW'(lo);
      end else if (g0 || g1) begin
        m_rv = 1'b1;
        m_addr = g1 ? up1_addr : up0_addr;
        m_inc  = g1 ? up1_inc : up0_inc;
        m_tag = '0; m_tag[IW] = g1; m_tag[IW-1:0] = g1 ? up1_id : up0_id;
        if (up0_valid && up1_valid) m_rr = g0;
      end else m_rv = 1'b0;
    end
    if (rtake) begin
      if (ispair) begin
        int k;
        k = int'(dn_rep_tag[IXW-1:0]);
        m_sv[0] = 1'b1; m_sval[0] = dn_rep_value; m_sid[0] = m_id0[k]; m_slab[0] = "R5";
        m_sv[1] = 1'b1; m_sval[1] = DW'(dn_rep_value + m_inc0[k]); m_sid[1] = m_id1[k];
        m_slab[1] = "R5";
        m_busy[k] = 1'b0;
      end else begin
        int p;
        p = int'(dn_rep_tag[IW]);
        m_sv[p] = 1'b1; m_sval[p] = dn_rep_value; m_sid[p] = dn_rep_tag[IW-1:0];
        m_slab[p] = "R6";
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (a0) begin q0.delete(0); up0_valid = 1'b0; end
    if (a1) begin q1.delete(0); up1_valid = 1'b0; end
    if (rtake) dn_rep_valid = 1'b0;
    if (!up0_valid && q0.size() > 0 && roll(p_in)) begin
      up0_valid = 1'b1; {up0_addr, up0_inc, up0_id} = q0[0];
    end
    if (!up1_valid && q1.size() > 0 && roll(p_in)) begin
      up1_valid = 1'b1; {up1_addr, up1_inc, up1_id} = q1[0];
    end
    if (!dn_rep_valid && !stall_mem && pend.size() > 0 && roll(p_rep)) begin
      int k;
      k = reorder ? int'($urandom_range(pend.size() - 1)) : 0;
      {dn_rep_tag, dn_rep_value} = pend[k];
      pend.delete(k);
      dn_rep_valid = 1'b1;
    end
    dn_req_ready  = roll(p_rdy);
    up0_rsp_ready = roll(p_rsp);
    up1_rsp_ready = roll(p_rsp);
    #1;
    model_cycle();
  endtask

  function automatic bit idle();
    return q0.size() == 0 && q1.size() == 0 && pend.size() == 0 && !m_rv
      && !m_sv[0] && !m_sv[1] && !up0_valid && !up1_valid && !dn_rep_valid
      && m_busy == '0;
  endfunction

  task automatic drain();
    int n;
    n = 0;
    while (!idle() && n < 20000) begin step(); n++; end
    if (!idle()) chk(1'b0, "R8 drain watchdog", 64'(n), 64'(0));
  endtask

  initial begin
    #1500000;
    chk(1'b0, "R9 global watchdog", 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    up0_valid = 0; up0_addr = 0; up0_inc = 0; up0_id = 0;
    up1_valid = 0; up1_addr = 0; up1_inc = 0; up1_id = 0;
    dn_req_ready = 0; dn_rep_valid = 0; dn_rep_tag = 0; dn_rep_value = 0;
    up0_rsp_ready = 0; up1_rsp_ready = 0;
    m_rv = 0; m_addr = 0; m_inc = 0; m_tag = 0; m_rr = 0; m_hold = 0; m_busy = '0;
    for (int p = 0; p < 2; p++) begin m_sv[p] = 0; m_sval[p] = 0; m_sid[p] = 0; m_slab[p] = "R6"; end
    p_in = 100; p_rdy = 100; p_rsp = 100; p_rep = 100; stall_mem = 0; reorder = 0;
    cnt_pair = 0; cnt_single = 0;
    repeat (3) @(negedge clk);
    // R9: nothing valid while in reset
    chk(!dn_req_valid && !up0_rsp_valid && !up1_rsp_valid, "R9 reset outputs",
        64'({dn_req_valid, up0_rsp_valid, up1_rsp_valid}), 0);
    rst_n = 1'b1;
    step();

    // R10 / R1: 5 with 1,1 merged then a lone 2
    mem[16'h10] = 5;
    got.delete();
    q0.push_back({16'h0010, 16'd1, 4'd1});
    q1.push_back({16'h0010, 16'd1, 4'd2});
    drain();
    chk(cnt_pair == 1 && cnt_single == 0, "R1 merged request count", 64'(cnt_pair), 1);
    q0.push_back({16'h0010, 16'd2, 4'd3});
    drain();
    got.sort();
    chk(got.size() == 3, "R10 result count", 64'(got.size()), 3);
    if (got.size() == 3)
      chk(got[0] == 5 && got[1] == 6 && got[2] == 7, "R10 serialized values",
          64'({16'(got[0]), 16'(got[1]), 16'(got[2])}), 64'({16'd5, 16'd6, 16'd7}));
    chk(mem[16'h10] == 9, "R10 final memory", 64'(mem[16'h10]), 9);

    // R3 / R4: memory stalled, buffer fills, later pairs go uncombined
    cnt_pair = 0; cnt_single = 0; pair_idx.delete();
    stall_mem = 1;
    for (int k = 0; k <= DEP; k++) begin
      q0.push_back({16'h0020, 16'd1, IW'(k)});
      q1.push_back({16'h0020, 16'd1, IW'(k + 8)});
    end
    repeat (30) step();
    chk(cnt_pair == DEP, "R3 merges until full", 64'(cnt_pair), 64'(DEP));
    chk(cnt_single == 2, "R3 uncombined when full", 64'(cnt_single), 2);
    for (int k = 0; k < DEP && k < pair_idx.size(); k++)
      chk(pair_idx[k] == k, "R4 lowest free slot", 64'(pair_idx[k]), 64'(k));
    stall_mem = 0;
    drain();
    chk(mem[16'h20] == 2 * (DEP + 1), "R10 total after full buffer", 64'(mem[16'h20]),
        64'(2 * (DEP + 1)));
    pair_idx.delete();
    q0.push_back({16'h0030, 16'd4, 4'd5});
    q1.push_back({16'h0030, 16'd6, 4'd6});
    drain();
    chk(pair_idx.size() == 1 && pair_idx[0] == 0, "R4 slot reuse after free",
        64'(pair_idx.size() > 0 ? pair_idx[0] : -1), 0);

    // R2 alternation: different addresses offered together
    cnt_single = 0;
    q0.push_back({16'h0040, 16'd1, 4'd1});
    q1.push_back({16'h0041, 16'd1, 4'd2});
    q0.push_back({16'h0042, 16'd1, 4'd3});
    q1.push_back({16'h0043, 16'd1, 4'd4});
    drain();
    chk(cnt_single == 4, "R2 all forwarded uncombined", 64'(cnt_single), 4);

    // R5 R6 R7 R8: random traffic, back-pressure, out-of-order replies
    got.delete();
    p_in = 70; p_rdy = 60; p_rsp = 55; p_rep = 50; reorder = 1;
    for (int k = 0; k < 300; k++) begin
      q0.push_back({AW'($urandom_range(7)), DW'($urandom), IW'($urandom)});
      q1.push_back({AW'($urandom_range(7)), DW'($urandom), IW'($urandom)});
    end
    drain();
    chk(got.size() == 600, "R6 every request answered", 64'(got.size()), 600);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule